// File: doc/BRIEF.md
# Write Start Gate with Power-Up Lockout

This block sits between the external control strobes of a byte-writable non-volatile memory and its internal write engine. It decides, one clock at a time, whether a write cycle may begin. It emits a single-cycle `wr_start` pulse only when four conditions all hold:

- The digital supply-good flag from an external comparator is high.
- The supply has stayed good for a programmable lockout interval.
- The control lines encode a write: chip select low, write strobe low, output enable high.
- The strobes have stayed in that state for a programmable minimum number of clock samples.

All four control inputs are active-low except `supply_ok`. Each is registered once on the system clock before any decision is made. The lockout and the filter width are given in clock cycles. A drop of the supply flag at any time restarts the lockout from zero. One qualifying strobe produces exactly one pulse, however long it lasts.

Top module: `wr_gate_top`

## Requirements
- R1: While `rst_n` is low `wr_start` is 0, and reset restarts the lockout, so no write can start until the full lockout has elapsed again after reset.
- R2: While `supply_ok` is sampled low, `wr_start` never pulses, whatever the control lines do.
- R3: If `supply_ok` rises with the strobes already held low (and `oe_n` high), `wr_start` is first high after rising edge number LOCK_CYC+FILT_CYC+1. The edges are counted from the first edge that samples the supply high.
- R4: A low on `supply_ok` sampled at even one edge restarts the lockout. A write strobe issued right after the supply returns produces no pulse.
- R5: A write is inhibited, with no pulse, whenever `oe_n` is low, `ce_n` is high or `we_n` is high.
- R6: When `ce_n` and `we_n` are both sampled low (with `oe_n` high) at fewer than FILT_CYC consecutive edges, no pulse is produced. At exactly FILT_CYC or more such edges, one pulse is produced.
- R7: Each qualifying strobe yields exactly one pulse, one cycle wide. A strobe that is released for a single sample and then asserted again yields a second pulse.
- R8: Once unlocked, `wr_start` is first high after rising edge number FILT_CYC+1, counted from the edge that first samples the strobes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Digital supply-above-threshold flag |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| wr_start | output | 1 | One-cycle write start pulse to the write engine |

## Verification
The bench builds the block with LOCK_CYC=20 and FILT_CYC=3. With these values the end of the lockout window and the filter threshold both fall within a few dozen cycles. Strobes of one, two, three and more samples can then be placed exactly either side of the filter edge. A supply dip, a mid-run reset and a power-up with strobes already asserted can each be traced to the exact edge at which the pulse must appear or must stay absent.

// File: rtl/wg_pkg.sv
// Package: shared types and helpers for the write start gate.
// Assumes: all control lines are active low except the supply flag.
package wg_pkg;

    // One registered snapshot of the block's control inputs.
    typedef struct packed {
        logic sup;
        logic ce_n;
        logic oe_n;
        logic we_n;
    } wg_lines_t;

    // Idle value: supply not good, all strobes released.
    localparam wg_lines_t WG_LINES_IDLE = '{sup: 1'b0, ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};

    // Counter width able to hold values 0..max_val.
    function automatic int unsigned wg_cnt_w(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/wg_input_sampler.sv
// Module: wg_input_sampler
// Registers the supply flag and the control strobes once on the system clock.
// Assumes: the inputs are already synchronous to clk, or their metastability
// is handled upstream; one register stage fixes the decision latency.
module wg_input_sampler
    import wg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  wg_lines_t raw_i,
    output wg_lines_t smp_o
);

    // Capture the raw lines; reset to the idle (inhibited) state.
    always_ff @(posedge clk) begin
        if (!rst_n) smp_o <= WG_LINES_IDLE;
        else        smp_o <= raw_i;
    end

    // Right after reset no write strobe can appear as sampled.
    AST_SMP_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (smp_o == WG_LINES_IDLE)); // R1

endmodule

// File: rtl/wg_lockout.sv
// Module: wg_lockout
// Power-up lockout timer. It counts consecutive cycles of good supply and
// asserts ok_o only once LOCK_CYC such cycles have passed. It clears on any
// sampled supply drop or on reset.
// Assumes: LOCK_CYC >= 1; sup_i is the registered supply flag.
module wg_lockout
    import wg_pkg::*;
#(
    parameter int unsigned LOCK_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_i,
    output logic ok_o
);

    localparam int unsigned CW = wg_cnt_w(LOCK_CYC);
    localparam logic [CW-1:0] LOCK_MAX = CW'(LOCK_CYC);

    logic [CW-1:0] good_cnt;

    // Count good-supply cycles, saturating at the lockout length.
    always_ff @(posedge clk) begin
        if (!rst_n)                 good_cnt <= '0;
        else if (!sup_i)            good_cnt <= '0;
        else if (good_cnt != LOCK_MAX) good_cnt <= good_cnt + 1'b1;
    end

    // Unlocked only while supply is still good and the timer is full.
    always_comb ok_o = sup_i && (good_cnt == LOCK_MAX);

    // Unlock implies the supply is currently good.
    AST_OK_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |-> sup_i); // R2

    // A sampled supply drop keeps the block locked on the next cycle.
    AST_DROP_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_i |=> !ok_o); // R4

    // The unlock cannot appear directly after a reset.
    AST_RESET_LOCKED: assert property (@(posedge clk)
        !rst_n |=> !ok_o); // R1

endmodule

// File: rtl/wg_inhibit_decode.sv
// Module: wg_inhibit_decode
// Decodes the sampled control lines into a single "write requested" level.
// A write is requested only with chip select low, write strobe low and
// output enable high; any other combination inhibits.
// Assumes: inputs are registered samples.
module wg_inhibit_decode
    import wg_pkg::*;
(
    input  wg_lines_t smp_i,
    output logic      wr_req_o
);

    logic inhibit;

    // Any of the three inhibit terms blocks the request.
    always_comb inhibit = !smp_i.oe_n || smp_i.ce_n || smp_i.we_n;

    // Request is the complement of inhibit.
    always_comb wr_req_o = !inhibit;

    // A request always coincides with both strobes low and OE released.
    AST_REQ_STROBES: assert final (!wr_req_o ||
        (!smp_i.ce_n && !smp_i.we_n && smp_i.oe_n)); // R5

endmodule

// File: rtl/wg_strobe_filter.sv
// Module: wg_strobe_filter
// Minimum-width filter and one-shot. It counts consecutive cycles in which
// a write is requested while unlocked, and fires one single-cycle pulse when
// the count reaches FILT_CYC. It fires again only after the qualifying
// condition has been absent.
// Assumes: FILT_CYC >= 1.
module wg_strobe_filter
    import wg_pkg::*;
#(
    parameter int unsigned FILT_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_req_i,
    input  logic ok_i,
    output logic fire_o
);

    localparam int unsigned CW = wg_cnt_w(FILT_CYC);
    localparam logic [CW-1:0] FILT_MAX  = CW'(FILT_CYC);
    localparam logic [CW-1:0] FILT_LAST = CW'(FILT_CYC - 1);

    logic          qual;
    logic [CW-1:0] low_cnt;

    // Qualifying level: request present and lockout expired.
    always_comb qual = wr_req_i && ok_i;

    // Width counter: clears when qualification drops, saturates at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                    low_cnt <= '0;
        else if (!qual)                low_cnt <= '0;
        else if (low_cnt != FILT_MAX)  low_cnt <= low_cnt + 1'b1;
    end

    // One-shot: pulse in the cycle after the width limit is met.
    always_ff @(posedge clk) begin
        if (!rst_n) fire_o <= 1'b0;
        else        fire_o <= qual && (low_cnt == FILT_LAST);
    end

    // The start pulse is exactly one cycle wide.
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o); // R7

    // A pulse needs the lockout to have expired on the cycle before.
    AST_FIRE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> $past(ok_i)); // R3

    // A pulse needs a request present on the cycle before.
    AST_FIRE_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> $past(wr_req_i)); // R6

endmodule

// File: rtl/wr_gate_top.sv
// Module: wr_gate_top
// Write start gate: a sampler, a power-up lockout timer, the write-inhibit
// decode and a minimum-width strobe filter with one-shot output.
// Assumes: synchronous inputs; LOCK_CYC >= 1 and FILT_CYC >= 1 in cycles.
module wr_gate_top
    import wg_pkg::*;
#(
    parameter int unsigned LOCK_CYC = 20,
    parameter int unsigned FILT_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic wr_start
);

    wg_lines_t raw_lines;
    wg_lines_t smp_lines;
    logic      unlocked;
    logic      wr_req;

    // Bundle the raw pins into one snapshot.
    always_comb raw_lines = '{sup: supply_ok, ce_n: ce_n, oe_n: oe_n, we_n: we_n};

    wg_input_sampler u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (raw_lines),
        .smp_o (smp_lines)
    );

    wg_lockout #(.LOCK_CYC(LOCK_CYC)) u_lockout (
        .clk   (clk),
        .rst_n (rst_n),
        .sup_i (smp_lines.sup),
        .ok_o  (unlocked)
    );

    wg_inhibit_decode u_decode (
        .smp_i    (smp_lines),
        .wr_req_o (wr_req)
    );

    wg_strobe_filter #(.FILT_CYC(FILT_CYC)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req_i (wr_req),
        .ok_i     (unlocked),
        .fire_o   (wr_start)
    );

    // A pulse never follows a cycle with OE sampled low.
    AST_OE_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |-> $past(smp_lines.oe_n)); // R5

    // A pulse never follows a cycle with the supply sampled low.
    AST_SUPPLY_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |-> $past(smp_lines.sup)); // R2

endmodule

// File: tb/wr_gate_top_tb_top.sv
// Bench for wr_gate_top: a vector table of strobe shapes followed by
// directed checks of reset, supply loss, power-up and back-to-back strobes.
module wr_gate_top_tb_top;

    localparam int unsigned LOCK = 20;
    localparam int unsigned FILT = 3;
    localparam int TAIL = FILT + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic ce_n = 1'b1;
    logic oe_n = 1'b1;
    logic we_n = 1'b1;
    logic wr_start;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int pulses;
    int first_idx;

    always #4 clk = ~clk;

    wr_gate_top #(.LOCK_CYC(LOCK), .FILT_CYC(FILT)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .wr_start  (wr_start)
    );

    // Vector: line levels during the strobe, samples held, expected pulses.
    typedef struct packed {
        logic       v_ce;
        logic       v_oe;
        logic       v_we;
        logic [7:0] width;
        logic [3:0] exp_p;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b0, 8'd5,  4'd1},  // R6 long strobe
        '{1'b0, 1'b1, 1'b0, 8'd3,  4'd1},  // R6 exactly the limit
        '{1'b0, 1'b1, 1'b0, 8'd2,  4'd0},  // R6 one short
        '{1'b0, 1'b1, 1'b0, 8'd1,  4'd0},  // R6 single-sample glitch
        '{1'b0, 1'b0, 1'b0, 8'd6,  4'd0},  // R5 OE low
        '{1'b1, 1'b1, 1'b0, 8'd6,  4'd0},  // R5 CE high
        '{1'b0, 1'b1, 1'b1, 8'd6,  4'd0},  // R5 WE high
        '{1'b0, 1'b1, 1'b0, 8'd20, 4'd1},  // R7 very long strobe, one pulse
        '{1'b1, 1'b0, 1'b1, 8'd6,  4'd0},  // R5 read-style idle
        '{1'b0, 1'b1, 1'b0, 8'd4,  4'd1}   // R6 just over the limit
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Hold the given levels for w samples, release, count pulses.
    task automatic strobe(input logic c, input logic o, input logic w,
                          input int width, output int np, output int fi);
        np = 0;
        fi = -1;
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = w;
        for (int i = 1; i <= width + TAIL; i++) begin
            @(negedge clk);
            if (wr_start) begin
                np++;
                if (fi < 0) fi = i;
            end
            if (i == width) begin
                ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        $display("FAIL watchdog: actual 1 expected 0");
        n_bad++;
        n_chk++;
        if (!done) $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int prev;
        int wide;
        // R1: reset state
        idle(4);
        chk("R1 wr_start in reset", int'(wr_start), 0);
        @(negedge clk); rst_n = 1'b1;
        idle(3);
        chk("R1 wr_start after reset", int'(wr_start), 0);

        // R2: supply low, strobe of ample width
        strobe(1'b0, 1'b1, 1'b0, 10, pulses, first_idx);
        chk("R2 supply low pulses", pulses, 0);

        // R3: supply rises with strobe already held
        @(negedge clk);
        supply_ok = 1'b1; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        pulses = 0; first_idx = -1;
        for (int i = 1; i <= int'(LOCK + FILT) + 10; i++) begin
            @(negedge clk);
            if (wr_start) begin
                pulses++;
                if (first_idx < 0) first_idx = i;
            end
        end
        ce_n = 1'b1; we_n = 1'b1;
        chk("R3 first pulse edge", first_idx, int'(LOCK + FILT) + 1);
        chk("R3 pulse count", pulses, 1);
        idle(4);

        // Table walk (unlocked)
        for (int v = 0; v < NV; v++) begin
            strobe(VECS[v].v_ce, VECS[v].v_oe, VECS[v].v_we,
                   int'(VECS[v].width), pulses, first_idx);
            chk($sformatf("R5/R6/R7 vector %0d pulses", v), pulses, int'(VECS[v].exp_p));
            if (VECS[v].exp_p != 0)
                chk($sformatf("R8 vector %0d latency", v), first_idx, int'(FILT) + 1);
            idle(2);
        end

        // R7: back-to-back strobes with a one-sample release, one-cycle width
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0;
        pulses = 0; prev = 0; wide = 0;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if (wr_start) begin
                pulses++;
                if (prev != 0) wide++;
            end
            prev = int'(wr_start);
            if (i == 4) begin ce_n = 1'b1; we_n = 1'b1; end
            if (i == 5) begin ce_n = 1'b0; we_n = 1'b0; end
            if (i == 9) begin ce_n = 1'b1; we_n = 1'b1; end
        end
        chk("R7 back-to-back pulses", pulses, 2);
        chk("R7 pulse wider than one cycle", wide, 0);
        idle(2);

        // R4: one-sample supply dip restarts lockout
        @(negedge clk); supply_ok = 1'b0;
        @(negedge clk); supply_ok = 1'b1;
        strobe(1'b0, 1'b1, 1'b0, 5, pulses, first_idx);
        chk("R4 strobe after dip", pulses, 0);
        idle(LOCK + 2);
        strobe(1'b0, 1'b1, 1'b0, 5, pulses, first_idx);
        chk("R4 strobe after relock", pulses, 1);
        idle(2);

        // R1: reset mid-run restarts lockout
        @(negedge clk); rst_n = 1'b0;
        idle(3);
        chk("R1 wr_start during mid reset", int'(wr_start), 0);
        rst_n = 1'b1;
        strobe(1'b0, 1'b1, 1'b0, 5, pulses, first_idx);
        chk("R1 strobe right after reset", pulses, 0);
        idle(LOCK + 2);
        strobe(1'b0, 1'b1, 1'b0, 5, pulses, first_idx);
        chk("R8 latency after reset unlock", first_idx, int'(FILT) + 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule